// File: doc/BRIEF.md
# Asymmetric Multilevel Bridge Gate Sequencer

This block drives the eight switch enables of two full bridges connected in series on one phase. The first bridge runs from a unit DC supply and the second from half of it, so together they produce seven output levels in half-unit steps. The block walks a fixed staircase of levels and moves one step for each carrier-period strobe. Alongside the gates it reports the current level as a signed count of half-units.

A small two-state machine controls the sequence. In the `ST_OFF` state every gate is held low and each step counter is held at its start position. The transition `OFF->RUN` is taken on the first clock edge where `en` is high. In `ST_RUN` the machine stays put (`RUN->RUN`) while `en` is high and advances the step counters on each `tick`. The transition `RUN->OFF` is taken on the first edge where `en` is low, and it also returns the counters to their start positions. Reset forces `ST_OFF`.

Up to three phases share the state machine. Each phase has its own step counter, and the start positions are spaced a third of the sequence apart so that each later phase lags the one before it by 120 degrees.

Top module: `mlv_stair_seq`

## Requirements
- R1: While reset is high, and in every cycle where the state is `ST_OFF`, all gate bits of all phases are 0 and every level code is 0.
- R2: The level code is a signed 3-bit count of half-units. In `ST_RUN`, phase 0 steps through the 11 indices 0..10 with levels +1,+2,+3,+2,+1,0,-1,-2,-3,-2,-1 and then wraps to index 0. The index advances by exactly one on each clock edge where `en` and `tick` are both high, and holds on every other edge.
- R3: On the edge that takes `OFF->RUN`, the step index is not advanced even if `tick` is high, so phase 0 shows level +1 in the cycle after entry. A `tick` that arrives while in `ST_OFF` has no effect.
- R4: A low `en` in `ST_RUN` takes `RUN->OFF` at the next edge and resets every step index to its start. After the next `OFF->RUN`, the phase 0 sequence starts again at +1.
- R5: Bridge 1 of a phase uses gate bits [3:0] = {S4,S3,S2,S1}. The codes are 4'b1001 for +1 unit (the diagonal S1,S4), 4'b0110 for -1 unit (the diagonal S2,S3) and 4'b1100 for zero (both lower switches S3,S4).
- R6: Bridge 2 uses gate bits [7:4] with the same encoding for +0.5, -0.5 and zero.
- R7: In `ST_RUN`, the level code equals 2·(bridge 1 value) + (bridge 2 value) in half-units. Bridge 2 is nonzero exactly when the level is odd.
- R8: The two switches of one leg are never on together: S1 with S3, and S2 with S4, in both bridges.
- R9: Phase k uses gates [8k+7:8k] and level [3k+2:3k]. Its index starts at (11 − round(11k/3)) mod 11, which is 7 for phase 1 and 4 for phase 2. It advances together with phase 0.
- R10: Each negative-half step (indices 6..10) has the gate pattern of the matching positive step (indices 0..4) with the nonzero bridges' polarity swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces the off state |
| tick | input | 1 | Carrier-period strobe, one cycle wide |
| gates | output | 8*NUM_PHASES | Switch enables, 8 per phase |
| levels | output | 3*NUM_PHASES | Signed half-unit level code, 3 bits per phase |

## Verification
The assertions assume that `tick` and `en` are synchronous to `clk`. They place no limit on the spacing of ticks: the step and hold properties must hold for a tick on every cycle, for long gaps between ticks, and for a tick on the same edge as entry into the run state. They also assume that reset can be raised at any time, so each property is disabled while it is high. The stimulus drives all inputs on the falling clock edge and covers each of these patterns, including ticks while disabled, enable dropping mid-sequence, and reset asserted during a run.

// File: rtl/mlv_pkg.sv
package mlv_pkg;
    localparam int SEQ_LEN = 11;
    localparam int IDX_W   = $clog2(SEQ_LEN);

    typedef logic signed [2:0] lvl_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef enum logic {ST_OFF, ST_RUN} st_t;

    // Staircase level in half-units for a step index.
    function automatic lvl_t step_level(idx_t i);
        lvl_t v;
        unique case (i)
            4'd0, 4'd4:  v = 3'sd1;
            4'd1, 4'd3:  v = 3'sd2;
            4'd2:        v = 3'sd3;
            4'd6, 4'd10: v = -3'sd1;
            4'd7, 4'd9:  v = -3'sd2;
            4'd8:        v = -3'sd3;
            default:     v = 3'sd0;
        endcase
        return v;
    endfunction

    // Start index of phase k: lag of round(k*SEQ_LEN/3) steps.
    function automatic int phase_start(int k);
        int off;
        off = (2 * k * SEQ_LEN + 3) / 6;
        return (SEQ_LEN - (off % SEQ_LEN)) % SEQ_LEN;
    endfunction
endpackage

// File: rtl/mlv_step_ctr.sv
module mlv_step_ctr
    import mlv_pkg::*;
#(
    parameter int START = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic adv,
    output idx_t idx
);
    localparam idx_t START_I = idx_t'(START);
    localparam idx_t LAST_I  = idx_t'(SEQ_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            idx <= START_I;
        else if (adv)
            idx <= (idx == LAST_I) ? '0 : idx + idx_t'(1);
    end
endmodule

// File: rtl/mlv_bridge_enc.sv
module mlv_bridge_enc
    import mlv_pkg::*;
(
    input  logic       on,
    input  lvl_t       lvl,
    output logic [7:0] gate
);
    localparam logic [3:0] NIB_POS  = 4'b1001;
    localparam logic [3:0] NIB_NEG  = 4'b0110;
    localparam logic [3:0] NIB_ZERO = 4'b1100;

    logic       neg;
    logic [2:0] mag;

    always_comb begin
        neg = lvl[2];
        mag = neg ? 3'(-lvl) : 3'(lvl);
        if (!on) begin
            gate = 8'h00;
        end else begin
            gate[3:0] = mag[1] ? (neg ? NIB_NEG : NIB_POS) : NIB_ZERO;
            gate[7:4] = mag[0] ? (neg ? NIB_NEG : NIB_POS) : NIB_ZERO;
        end
    end
endmodule

// File: rtl/mlv_stair_seq.sv
module mlv_stair_seq
    import mlv_pkg::*;
#(
    parameter int NUM_PHASES = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    tick,
    output logic [8*NUM_PHASES-1:0] gates,
    output logic [3*NUM_PHASES-1:0] levels
);
    st_t  state, state_nx;
    logic running;
    logic clear_idx;
    logic advance;

    always_comb begin
        unique case (state)
            ST_OFF:  state_nx = en ? ST_RUN : ST_OFF;
            ST_RUN:  state_nx = en ? ST_RUN : ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_OFF;
        else
            state <= state_nx;
    end

    always_comb begin
        running   = (state == ST_RUN);
        clear_idx = !(running && en);
        advance   = running && en && tick;
    end

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase
        idx_t idx;
        lvl_t lvl;

        mlv_step_ctr #(.START(phase_start(k))) u_ctr (
            .clk   (clk),
            .rst   (rst),
            .clear (clear_idx),
            .adv   (advance),
            .idx   (idx)
        );

        assign lvl = running ? step_level(idx) : 3'sd0;
        assign levels[3*k+2:3*k] = lvl;

        mlv_bridge_enc u_enc (
            .on   (running),
            .lvl  (lvl),
            .gate (gates[8*k+7:8*k])
        );
    end
endmodule

// File: rtl/mlv_stair_seq_chk.sv
module mlv_stair_seq_chk #(
    parameter int NUM_PHASES = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic                    tick,
    input logic                    running,
    input logic [8*NUM_PHASES-1:0] gates,
    input logic [3*NUM_PHASES-1:0] levels
);
    function automatic int nib_val(logic [3:0] n);
        return (n == 4'b1001) ? 1 : (n == 4'b0110) ? -1 : 0;
    endfunction

    // R1: disabled means all gates off.
    p_off_gates_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gates == '0 && levels == '0));

    // R3: entry shows the first step, +0.5 unit.
    p_entry_level_r3: assert property (@(posedge clk) disable iff (rst)
        (!running && en) |=> (levels[2:0] == 3'd1));

    // R2: hold without a tick.
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (running && en && !tick) |=> $stable(levels));

    // R2: a tick always moves to a different level.
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (running && en && tick) |=> !$stable(levels[2:0]));

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_chk
        // R8: no leg shorted in either bridge.
        p_leg_safe_r8: assert property (@(posedge clk) disable iff (rst)
            ((gates[8*k] & gates[8*k+2]) | (gates[8*k+1] & gates[8*k+3]) |
             (gates[8*k+4] & gates[8*k+6]) | (gates[8*k+5] & gates[8*k+7])) == 1'b0);

        // R7: level code agrees with the gate pattern.
        p_level_sum_r7: assert property (@(posedge clk) disable iff (rst)
            running |-> ($signed(levels[3*k+2:3*k]) ==
                         2 * nib_val(gates[8*k+3:8*k]) + nib_val(gates[8*k+7:8*k+4])));
    end
endmodule

bind mlv_stair_seq mlv_stair_seq_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .tick    (tick),
    .running (running),
    .gates   (gates),
    .levels  (levels)
);

// File: tb/test_mlv_stair_seq.sv
`timescale 1ns/1ps
module test_mlv_stair_seq;
    localparam int NP = 3;
    localparam int L  = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en = 1'b0;
    logic            tick = 1'b0;
    logic [8*NP-1:0] gates;
    logic [3*NP-1:0] levels;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int  m_idx [NP];
    bit  m_run;
    int  start_of [NP];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    mlv_stair_seq #(.NUM_PHASES(NP)) i_mlv_stair_seq (
        .clk(clk), .rst(rst), .en(en), .tick(tick),
        .gates(gates), .levels(levels)
    );

    function automatic int exp_level(int i);
        int j;
        j = (i <= 4) ? i : i - 6;
        if (i == 5) return 0;
        return ((i <= 4) ? 1 : -1) * ((j <= 2) ? j + 1 : 5 - j);
    endfunction

    function automatic logic [3:0] nib(int v);
        return (v > 0) ? 4'b1001 : (v < 0) ? 4'b0110 : 4'b1100;
    endfunction

    function automatic logic [7:0] exp_gate(int lv);
        int b2, b1;
        b2 = (lv % 2 != 0) ? ((lv > 0) ? 1 : -1) : 0;
        b1 = (lv - b2) / 2;
        return {nib(b2), nib(b1)};
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < NP; k++) begin
            logic [7:0] g;
            int lv_act, lv_exp;
            g = gates[8*k +: 8];
            lv_act = $signed(levels[3*k +: 3]);
            check("R8 leg exclusive", int'((g[0] & g[2]) | (g[1] & g[3]) | (g[4] & g[6]) | (g[5] & g[7])), 0);
            if (!m_run) begin
                check("R1 gates off", int'(g), 0);
                check("R1 level zero", lv_act, 0);
            end else begin
                lv_exp = exp_level(m_idx[k]);
                if (k == 0) begin
                    check("R2 level", lv_act, lv_exp);
                    if (m_idx[k] >= 6) check("R10 mirrored gates", int'(g), int'(exp_gate(lv_exp)));
                    else check("R5 R6 gates", int'(g), int'(exp_gate(lv_exp)));
                end else begin
                    check("R9 phase level", lv_act, lv_exp);
                    check("R9 phase gates", int'(g), int'(exp_gate(lv_exp)));
                end
                check("R7 level sum", lv_act, 2 * ((g[3:0] == 4'b1001) ? 1 : (g[3:0] == 4'b0110) ? -1 : 0)
                                              + ((g[7:4] == 4'b1001) ? 1 : (g[7:4] == 4'b0110) ? -1 : 0));
            end
        end
    endtask

    task automatic step(bit r, bit e, bit t);
        rst = r; en = e; tick = t;
        @(posedge clk);
        if (r) begin
            m_run = 0;
            for (int k = 0; k < NP; k++) m_idx[k] = start_of[k];
        end else if (!m_run) begin
            m_run = e;
            for (int k = 0; k < NP; k++) m_idx[k] = start_of[k];
        end else if (!e) begin
            m_run = 0;
            for (int k = 0; k < NP; k++) m_idx[k] = start_of[k];
        end else if (t) begin
            for (int k = 0; k < NP; k++) m_idx[k] = (m_idx[k] + 1) % L;
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        for (int k = 0; k < NP; k++) begin
            start_of[k] = (L - ((2 * k * L + 3) / 6) % L) % L;
            m_idx[k] = start_of[k];
        end
        m_run = 0;
        check("R9 phase1 start", start_of[1], 7);
        check("R9 phase2 start", start_of[2], 4);
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        check("R1 reset gates", int'(gates), 0);
        // R3: ticks while off are ignored
        for (int i = 0; i < 5; i++) step(0, 0, 1);
        // R3: tick on the entry edge not counted
        step(0, 1, 1);
        check("R3 entry level", int'($signed(levels[2:0])), 1);
        // R2: tick every cycle, over several wraps
        for (int i = 0; i < 40; i++) step(0, 1, 1);
        // R2: tick every third cycle
        for (int i = 0; i < 60; i++) step(0, 1, (i % 3) == 2);
        // R4: drop enable mid-sequence, then re-enable
        step(0, 0, 1);
        step(0, 0, 0);
        step(0, 1, 0);
        check("R4 restart level", int'($signed(levels[2:0])), 1);
        // pseudo-random ticks with occasional enable drops and resets
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:0] == 8'h5A, lfsr[6:0] != 7'h11, lfsr[0]);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule